// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic down-counter that gives a processor a steady time base. Software reaches it through a four-word register window. In that window it sets a reload value, picks the count source, enables the tick interrupt and starts counting. The counter steps down once per selected tick. The tick is either every core clock or each rising edge of an external reference strobe, which the block first synchronises to the core clock.

When a tick arrives while the count is zero, the period has ended. The block sets a sticky flag and, if the interrupt is enabled, drives a one-cycle request. It then starts the next period from the reload value. A period is therefore reload+1 ticks long. If the reload value is zero at that point, counting stops instead.

The register port is a single-cycle word interface. Read data and the error response are combinational in the cycle that `req_i` is high, and every side effect takes place at the end of that cycle. An access without privilege gets an error response and changes nothing.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset the control word (offset 0x0), the reload word (0x4) and the current-value word (0x8) all read 0, and `irq_o` is low.
- R2: A write to control changes only bits [2:0]: bit 0 is run enable, bit 1 is interrupt enable, bit 2 is the source select (1 = core clock, 0 = reference strobe). Bit 16 (the expiry flag) is not writable. All other bits read 0.
- R3: The reload word and the current-value word hold 24 bits, and bits [31:24] always read 0.
- R4: A control write that sets run enable while it is clear loads the counter from reload. With the core clock selected the count then drops by one every clock, and one period is reload+1 clocks.
- R5: With the reference source selected, the count drops by one for each rising edge of `ref_i` and holds while `ref_i` has no edges.
- R6: A tick at count zero sets flag bit 16. A privileged read of control returns the flag and clears it at the end of that read.
- R7: At each expiry with interrupt enable set, `irq_o` is high for exactly one cycle. With interrupt enable clear it stays low.
- R8: When the counter expires with a reload value of 0, run enable clears itself and counting stops.
- R9: A write of any data to the current-value word reloads the counter from reload and clears the flag.
- R10: The current-value word reads 0 while run enable is clear.
- R11: The calibration word (0xC) reads the constant 10000 (decimal) and ignores writes.
- R12: An access with `priv_i` low gets `err_o` high and read data 0, and it changes no state. This includes the flag, which a control read would otherwise clear.
- R13: A read of an unmapped or non-word-aligned offset returns 0 without error, and a write there has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the accessed word |
| wdata_i | input | 32 | Write data |
| priv_i | input | 1 | 1 = privileged access |
| rdata_o | output | 32 | Read data, valid while req_i is high |
| err_o | output | 1 | Error response for unprivileged access |
| ref_i | input | 1 | Asynchronous reference strobe |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
The bench builds the block with its default parameters: a 24-bit counter, an 8-bit offset space and a two-stage strobe synchroniser. The full 24-bit width makes the upper-bit masking of the reload word observable. Reload values of 0 and 3 bring self-stop and back-to-back periods within a few cycles. A large reload value makes single-step decrements visible without a wrap. The reference source is stepped by hand-driven strobe edges, so both holding and counting can be checked exactly.

// File: rtl/sys_tick_pkg.sv
package sys_tick_pkg;
  localparam int DATA_W   = 32;
  localparam int FLAG_BIT = 16;

  localparam logic [3:0] OFS_CTRL   = 4'h0;
  localparam logic [3:0] OFS_RELOAD = 4'h4;
  localparam logic [3:0] OFS_CUR    = 4'h8;
  localparam logic [3:0] OFS_CAL    = 4'hC;

  typedef struct packed {
    logic src;  // 1 = core clock
    logic ie;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/stt_ref_sync.sv
module stt_ref_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic pulse_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= ref_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], ref_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[SYNC_STAGES-1];

  assign pulse_o = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/stt_counter.sv
module stt_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step     = run_i & tick_i & ~load_i;
  assign expire_o = step & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (load_i)   cnt_q <= reload_i;
    else if (expire_o) cnt_q <= reload_i;
    else if (step)     cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/stt_regs.sv
module stt_regs
  import sys_tick_pkg::*;
#(
  parameter int              CNT_W   = 24,
  parameter int              ADDR_W  = 8,
  parameter logic [DATA_W-1:0] CAL_VAL = 32'd10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              priv_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              expire_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              flag_o,
  output logic              load_o,
  output logic              wr_ctrl_o
);
  localparam int PAD_W = DATA_W - CNT_W;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             flag_q;
  logic             acc_ok, mapped;
  logic             sel_ctrl, sel_reload, sel_cur, sel_cal;
  logic             wr_ctrl, wr_reload, wr_cur, rd_ctrl;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:CNT_W];

  assign acc_ok = req_i & priv_i;
  assign mapped = (addr_i[ADDR_W-1:4] == '0);
  assign sel_ctrl   = mapped & (addr_i[3:0] == OFS_CTRL);
  assign sel_reload = mapped & (addr_i[3:0] == OFS_RELOAD);
  assign sel_cur    = mapped & (addr_i[3:0] == OFS_CUR);
  assign sel_cal    = mapped & (addr_i[3:0] == OFS_CAL);

  assign wr_ctrl   = acc_ok &  we_i & sel_ctrl;
  assign wr_reload = acc_ok &  we_i & sel_reload;
  assign wr_cur    = acc_ok &  we_i & sel_cur;
  assign rd_ctrl   = acc_ok & ~we_i & sel_ctrl;

  // enable rising by write, or any write to current value, reloads
  assign load_o = (wr_ctrl & wdata_i[0] & ~ctrl_q.en) | wr_cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_ctrl)
        ctrl_q <= ctrl_t'(wdata_i[2:0]);
      else if (expire_i && reload_q == '0)
        ctrl_q.en <= 1'b0;
      if (wr_reload)
        reload_q <= wdata_i[CNT_W-1:0];
      if (expire_i)
        flag_q <= 1'b1;
      else if (rd_ctrl || wr_cur)
        flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (acc_ok && !we_i) begin
      if (sel_ctrl) begin
        rdata_o[2:0]      = ctrl_q;
        rdata_o[FLAG_BIT] = flag_q;
      end else if (sel_reload) begin
        rdata_o = {{PAD_W{1'b0}}, reload_q};
      end else if (sel_cur) begin
        rdata_o = ctrl_q.en ? {{PAD_W{1'b0}}, cnt_i} : '0;
      end else if (sel_cal) begin
        rdata_o = CAL_VAL;
      end
    end
  end

  assign err_o     = req_i & ~priv_i;
  assign ctrl_o    = ctrl_q;
  assign reload_o  = reload_q;
  assign flag_o    = flag_q;
  assign wr_ctrl_o = wr_ctrl;
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
  import sys_tick_pkg::*;
#(
  parameter int                CNT_W       = 24,
  parameter int                ADDR_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] CAL_VAL     = 32'd10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              priv_i,
  output logic [31:0]       rdata_o,
  output logic              err_o,
  input  logic              ref_i,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, cnt;
  logic             flag, load, expire, wr_ctrl, ref_pulse, tick, irq_q;

  stt_ref_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_i), .pulse_o(ref_pulse)
  );

  assign tick = ctrl.src ? 1'b1 : ref_pulse;

  stt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(ctrl.en), .tick_i(tick),
    .load_i(load), .reload_i(reload), .cnt_o(cnt), .expire_o(expire)
  );

  stt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .CAL_VAL(CAL_VAL)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .priv_i(priv_i),
    .rdata_o(rdata_o), .err_o(err_o), .cnt_i(cnt), .expire_i(expire),
    .ctrl_o(ctrl), .reload_o(reload), .flag_o(flag), .load_o(load),
    .wr_ctrl_o(wr_ctrl)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= expire & ctrl.ie;

  assign irq_o = irq_q;
endmodule

// File: rtl/sys_tick_timer_chk.sv
module sys_tick_timer_chk #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              priv_i,
  input logic [31:0]       rdata_o,
  input logic              err_o,
  input logic              irq_o,
  input logic              en,
  input logic              flag,
  input logic [CNT_W-1:0]  reload,
  input logic [CNT_W-1:0]  cnt,
  input logic              tick,
  input logic              load,
  input logic              expire,
  input logic              wr_ctrl
);
  logic rd_ok;
  assign rd_ok = req_i & priv_i & ~we_i;

  assert_irq_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  assert_irq_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag);
  assert_self_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && reload == '0 && !wr_ctrl) |=> !en);
  assert_count_down_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && tick && !load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  assert_flag_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> flag);
  assert_unpriv_resp_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !priv_i) |-> (err_o && rdata_o == '0));
  assert_unpriv_keep_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !priv_i) |=> $stable(reload));
  assert_cal_const_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ok && addr_i == ADDR_W'(12)) |-> rdata_o == 32'd10000);
  assert_cur_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ok && addr_i == ADDR_W'(8) && !en) |-> rdata_o == '0);
  assert_upper_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ok && (addr_i == ADDR_W'(4) || addr_i == ADDR_W'(8)))
      |-> rdata_o[31:CNT_W] == '0);
endmodule

bind sys_tick_timer sys_tick_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .priv_i(priv_i), .rdata_o(rdata_o), .err_o(err_o), .irq_o(irq_o),
  .en(ctrl.en), .flag(flag), .reload(reload), .cnt(cnt), .tick(tick),
  .load(load), .expire(expire), .wr_ctrl(wr_ctrl)
);

// File: tb/sys_tick_timer_tb.sv
module sys_tick_timer_tb;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0, we_i = 1'b0, priv_i = 1'b1, ref_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic              err_o, irq_o;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, irq_cnt = 0, irq_run = 0, irq_max_run = 0;
  int irq_stamp[$];

  always #4 clk = ~clk;

  sys_tick_timer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .priv_i(priv_i), .rdata_o(rdata_o), .err_o(err_o),
    .ref_i(ref_i), .irq_o(irq_o)
  );

  always @(negedge clk) begin
    cyc++;
    if (irq_o) begin
      irq_cnt++; irq_run++; irq_stamp.push_back(cyc);
      if (irq_run > irq_max_run) irq_max_run = irq_run;
    end else irq_run = 0;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                     input logic p, output logic [31:0] rd, output logic er);
    @(negedge clk);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d; priv_i = p;
    #2; rd = rdata_o; er = err_o;
    @(posedge clk); #1;
    req_i = 1'b0; we_i = 1'b0; priv_i = 1'b1;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    logic [31:0] rd; logic er;
    acc(1'b1, a, d, 1'b1, rd, er);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
    logic er;
    acc(1'b0, a, 32'h0, 1'b1, v, er);
  endtask

  task automatic ref_edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_i = 1'b1;
      repeat (3) @(negedge clk);
      ref_i = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  // leaves flag set, enable clear, source = core
  task automatic force_stop_expiry();
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0);
    wr(8'h00, 32'h5);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    rd(8'h00, v); chk("R1 control after reset", v, 32'h0);
    rd(8'h04, v); chk("R1 reload after reset", v, 32'h0);
    rd(8'h08, v); chk("R1 current after reset", v, 32'h0);
  endtask

  task automatic t_ctrl_fields();
    logic [31:0] v;
    wr(8'h00, 32'hFFFF_FFF8); rd(8'h00, v);
    chk("R2 upper control bits ignored", v, 32'h0);
    wr(8'h00, 32'h6); rd(8'h00, v);
    chk("R2 control bits 2:1 kept", v, 32'h6);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_reload_width();
    logic [31:0] v;
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v);
    chk("R3 reload upper bits zero", v, 32'h00FF_FFFF);
  endtask

  task automatic t_core_count();
    logic [31:0] a, b;
    wr(8'h04, 32'd1000);
    wr(8'h00, 32'h5);
    rd(8'h08, a); rd(8'h08, b);
    chk("R4 load on enable", a, 32'd1000);
    chk("R4 one step per clock", b, 32'd999);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_period_irq();
    int base;
    wr(8'h04, 32'd3);
    irq_stamp.delete(); irq_max_run = 0;
    wr(8'h00, 32'h7);
    while (irq_stamp.size() < 3) @(negedge clk);
    wr(8'h00, 32'h0);
    chk("R4 period reload+1 clocks (a)", irq_stamp[1] - irq_stamp[0], 32'd4);
    chk("R4 period reload+1 clocks (b)", irq_stamp[2] - irq_stamp[1], 32'd4);
    chk("R7 irq single cycle", irq_max_run, 32'd1);
    base = irq_cnt;
    wr(8'h00, 32'h5);
    repeat (20) @(negedge clk);
    wr(8'h00, 32'h0);
    chk("R7 no irq with interrupt disabled", irq_cnt - base, 32'd0);
  endtask

  task automatic t_ref_count();
    logic [31:0] v;
    wr(8'h04, 32'd100);
    wr(8'h00, 32'h1);
    rd(8'h08, v); chk("R5 loaded value", v, 32'd100);
    repeat (10) @(negedge clk);
    rd(8'h08, v); chk("R5 holds without strobe edges", v, 32'd100);
    ref_edges(3);
    rd(8'h08, v); chk("R5 one step per strobe edge", v, 32'd97);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_self_stop();
    logic [31:0] v;
    rd(8'h00, v);
    force_stop_expiry();
    rd(8'h00, v); chk("R8 enable cleared, R6 flag set", v, 32'h0001_0004);
    rd(8'h00, v); chk("R6 flag cleared by read", v, 32'h0000_0004);
    rd(8'h08, v); chk("R10 current reads 0 when disabled", v, 32'h0);
  endtask

  task automatic t_cur_write();
    logic [31:0] v;
    force_stop_expiry();
    wr(8'h04, 32'd50);
    wr(8'h00, 32'h1);
    ref_edges(5);
    rd(8'h08, v); chk("R9 pre-check count", v, 32'd45);
    wr(8'h08, 32'h0000_DEAD);
    rd(8'h08, v); chk("R9 current write reloads", v, 32'd50);
    rd(8'h00, v); chk("R9 current write clears flag", v, 32'h1);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_cal();
    logic [31:0] v;
    wr(8'h0C, 32'h5);
    rd(8'h0C, v); chk("R11 calibration constant", v, 32'd10000);
  endtask

  task automatic t_unpriv();
    logic [31:0] v; logic er;
    force_stop_expiry();
    acc(1'b1, 8'h04, 32'd77, 1'b0, v, er); chk("R12 write error", {31'b0, er}, 32'h1);
    acc(1'b1, 8'h00, 32'h3, 1'b0, v, er);
    acc(1'b0, 8'h00, 32'h0, 1'b0, v, er);
    chk("R12 read error", {31'b0, er}, 32'h1);
    chk("R12 read data zero", v, 32'h0);
    rd(8'h04, v); chk("R12 reload unchanged", v, 32'h0);
    rd(8'h00, v); chk("R12 control and flag unchanged", v, 32'h0001_0004);
  endtask

  task automatic t_unmapped();
    logic [31:0] v; logic er;
    wr(8'h04, 32'd9);
    acc(1'b0, 8'h10, 32'h0, 1'b1, v, er);
    chk("R13 unmapped read zero", v, 32'h0);
    chk("R13 unmapped no error", {31'b0, er}, 32'h0);
    acc(1'b0, 8'h06, 32'h0, 1'b1, v, er);
    chk("R13 misaligned read zero", v, 32'h0);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF);
    rd(8'h04, v); chk("R13 unmapped write ignored (reload)", v, 32'd9);
    rd(8'h00, v); chk("R13 unmapped write ignored (control)", v, 32'h4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_ctrl_fields();
    t_reload_width();
    t_core_count();
    t_period_irq();
    t_ref_count();
    t_self_stop();
    t_cur_write();
    t_cal();
    t_unpriv();
    t_unmapped();
    summary();
    $finish;
  end
endmodule